// File: doc/BRIEF.md
# Pin Configuration Write Guard

This block keeps the pad-configuration bits of chosen pins, typically a pin that doubles as a non-maskable interrupt input, from being altered by a stray software write. Software must first present a 32-bit unlock key to a lock register. Only while the port is unlocked may it set per-pin commit bits. A protected pin's alternate-function, pull-up, pull-down and digital-enable bits follow a write only while that pin's commit bit is 1. Pins outside the protected set are always writable, and the direction register is never gated.

The block holds the commit mask, the lock state and the five per-pin configuration registers behind one simple write strobe and address/data bus. Reads are combinational on the same address. The protected set is fixed at build time by a parameter mask. The commit mask is also driven out so that neighbouring configuration logic can use it.

Top module: `pin_guard`

## Requirements
- R1: Writing exactly 0x4C4F434B to the lock register (byte offset 0x520) unlocks the port from the next cycle.
- R2: Writing any other 32-bit value to offset 0x520, including 0 and every single-bit change of the key, locks the port. Reading 0x520 returns 1 when locked and 0 when unlocked. Reset leaves the port locked.
- R3: A write to the commit register (offset 0x524) is ignored while the port is locked.
- R4: Commit bits of protected pins (PROT_MASK bit = 1) reset to 0 and follow writes made while unlocked. Commit bits of unprotected pins always read 1.
- R5: The gated registers are alternate-function select (0x420), pull-up (0x510), pull-down (0x514) and digital enable (0x51C). On a write to any of them, bit i takes the written value only if commit bit i is 1. Otherwise bit i keeps its old value.
- R6: The direction register (0x400) takes every written bit, whatever the lock and commit state.
- R7: Each register reads back at its own offset in bits [N-1:0]. Upper bits read 0, and any other offset reads 0.
- R8: All five configuration registers reset to 0.
- R9: Relocking does not clear commit bits, so a protected pin that is already committed stays writable after relock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 12 | Byte offset for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data at addr |
| commit_mask | output | N | Per-pin commit mask (1 = writable) |
| dir_q | output | N | Direction register |
| alt_sel | output | N | Alternate-function select register |
| pull_up | output | N | Pull-up enable register |
| pull_dn | output | N | Pull-down enable register |
| dig_en | output | N | Digital-enable register |

## Verification
Each gated register is written with all-ones, all-zeros and two alternating patterns under four commit masks: none, one and both protected pins committed, plus the mask left over after a relock. This separates bits that must hold from bits that must follow. The key is tried exactly and with each of its 32 bits flipped, which shows that only the exact value unlocks. Commit writes are tried both locked and unlocked, which shows that the lock really gates them. Direction writes made while locked and uncommitted show that this register is outside the gate.

// File: rtl/pin_guard_pkg.sv
`timescale 1ns/1ps
// Shared constants for the pin configuration write guard: register
// offsets, the unlock key and the field index order.
package pin_guard_pkg;
    localparam int          ADDR_W  = 12;
    localparam int          DATA_W  = 32;
    localparam int          NFIELD  = 5;
    localparam logic [31:0] UNLOCK_KEY = 32'h4C4F434B;

    localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_AFSEL = 12'h420;
    localparam logic [ADDR_W-1:0] OFS_PUP   = 12'h510;
    localparam logic [ADDR_W-1:0] OFS_PDN   = 12'h514;
    localparam logic [ADDR_W-1:0] OFS_DEN   = 12'h51C;
    localparam logic [ADDR_W-1:0] OFS_LOCK  = 12'h520;
    localparam logic [ADDR_W-1:0] OFS_COMMIT = 12'h524;

    // Field index 0 is direction (ungated); 1..4 are gated.
    function automatic logic [ADDR_W-1:0] field_ofs(input int idx);
        case (idx)
            0:       return OFS_DIR;
            1:       return OFS_AFSEL;
            2:       return OFS_PUP;
            3:       return OFS_PDN;
            default: return OFS_DEN;
        endcase
    endfunction
endpackage

// File: rtl/pin_lock_key.sv
`timescale 1ns/1ps
// Lock state holder. Assumes one write per cycle; any write that is not
// the exact key locks the port. Resets locked.
module pin_lock_key
    import pin_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);
    // Update lock state on a lock-register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b1;
        else if (we)
            locked <= (wdata != UNLOCK_KEY);
    end
endmodule

// File: rtl/pin_commit_reg.sv
`timescale 1ns/1ps
// Per-pin commit mask. Flops exist only for protected pins; unprotected
// pins read a constant 1. Writes land only while unlocked.
module pin_commit_reg #(
    parameter int             N         = 8,
    parameter logic [N-1:0]   PROT_MASK = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         unlocked,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            if (PROT_MASK[i]) begin : g_prot
                logic bit_q;
                // Hold the commit bit; change only on an unlocked write.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        bit_q <= 1'b0;
                    else if (we && unlocked)
                        bit_q <= wdata[i];
                end
                assign mask[i] = bit_q;
            end else begin : g_open
                assign mask[i] = 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/pin_cfg_field.sv
`timescale 1ns/1ps
// One per-pin configuration register. With GATED set, bit i follows a
// write only where cmask[i] is 1; otherwise every bit follows. Resets to 0.
module pin_cfg_field #(
    parameter int N     = 8,
    parameter bit GATED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] cmask,
    output logic [N-1:0] q
);
    logic [N-1:0] nxt;

    generate
        if (GATED) begin : g_gated
            // Merge written bits where committed, keep the rest.
            assign nxt = (q & ~cmask) | (wdata & cmask);
        end else begin : g_plain
            logic [N-1:0] unused_mask;
            assign unused_mask = cmask;
            // Ungated register takes the whole write.
            assign nxt = wdata;
        end
    endgenerate

    // Register the field value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= nxt;
    end
endmodule

// File: rtl/pin_guard.sv
`timescale 1ns/1ps
// Pin configuration write guard. Decodes the register offsets, holds the
// lock state, the commit mask and five per-pin configuration registers,
// and returns read data combinationally. Assumes at most one write per
// cycle and byte offsets on addr.
module pin_guard
    import pin_guard_pkg::*;
#(
    parameter int           N         = 8,
    parameter logic [N-1:0] PROT_MASK = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [N-1:0]      commit_mask,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      alt_sel,
    output logic [N-1:0]      pull_up,
    output logic [N-1:0]      pull_dn,
    output logic [N-1:0]      dig_en
);
    logic         locked;
    logic         lock_we;
    logic         commit_we;
    logic [N-1:0] field_q [NFIELD];

    assign lock_we   = wr_en && (addr == OFS_LOCK);
    assign commit_we = wr_en && (addr == OFS_COMMIT);

    pin_lock_key u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (lock_we),
        .wdata  (wdata),
        .locked (locked)
    );

    pin_commit_reg #(.N(N), .PROT_MASK(PROT_MASK)) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (commit_we),
        .unlocked (!locked),
        .wdata    (wdata[N-1:0]),
        .mask     (commit_mask)
    );

    genvar f;
    generate
        for (f = 0; f < NFIELD; f++) begin : g_field
            logic field_we;
            assign field_we = wr_en && (addr == field_ofs(f));
            pin_cfg_field #(.N(N), .GATED(f != 0)) u_field (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (field_we),
                .wdata (wdata[N-1:0]),
                .cmask (commit_mask),
                .q     (field_q[f])
            );
        end
    endgenerate

    assign dir_q   = field_q[0];
    assign alt_sel = field_q[1];
    assign pull_up = field_q[2];
    assign pull_dn = field_q[3];
    assign dig_en  = field_q[4];

    // Select read data by offset; unmatched offsets read zero.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NFIELD; k++)
            if (addr == field_ofs(k))
                rdata[N-1:0] = field_q[k];
        if (addr == OFS_LOCK)
            rdata[0] = locked;
        if (addr == OFS_COMMIT)
            rdata[N-1:0] = commit_mask;
    end
endmodule

// File: rtl/pin_guard_chk.sv
`timescale 1ns/1ps
// Property checker for pin_guard, attached by bind below.
module pin_guard_chk
    import pin_guard_pkg::*;
#(
    parameter int N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              locked,
    input logic [N-1:0]      commit_mask,
    input logic [N-1:0]      dir_q,
    input logic [N-1:0]      alt_sel,
    input logic [N-1:0]      pull_up,
    input logic [N-1:0]      pull_dn,
    input logic [N-1:0]      dig_en
);
    a_r1_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_LOCK && wdata == UNLOCK_KEY) |=> !locked);

    a_r2_other_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_LOCK && wdata != UNLOCK_KEY) |=> locked);

    a_r2_reset_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> locked);

    a_r3_commit_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_COMMIT && locked) |=> $stable(commit_mask));

    a_r5_afsel_gated: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((alt_sel ^ $past(alt_sel)) & ~$past(commit_mask)) == '0);

    a_r5_pup_gated: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pull_up ^ $past(pull_up)) & ~$past(commit_mask)) == '0);

    a_r5_pdn_gated: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pull_dn ^ $past(pull_dn)) & ~$past(commit_mask)) == '0);

    a_r5_den_gated: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dig_en ^ $past(dig_en)) & ~$past(commit_mask)) == '0);

    a_r6_dir_open: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DIR) |=> dir_q == $past(wdata[N-1:0]));
endmodule

bind pin_guard pin_guard_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .locked      (locked),
    .commit_mask (commit_mask),
    .dir_q       (dir_q),
    .alt_sel     (alt_sel),
    .pull_up     (pull_up),
    .pull_dn     (pull_dn),
    .dig_en      (dig_en)
);

// File: tb/pin_guard_test.sv
`timescale 1ns/1ps
module pin_guard_test;
    import pin_guard_pkg::*;

    localparam int       N    = 8;
    localparam [N-1:0]   PROT = 8'h05;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [N-1:0]      commit_mask, dir_q, alt_sel, pull_up, pull_dn, dig_en;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [N-1:0] m_cfg [NFIELD];
    logic [N-1:0] m_cm;

    always #10 clk = ~clk;

    pin_guard #(.N(N), .PROT_MASK(PROT)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .commit_mask(commit_mask), .dir_q(dir_q),
        .alt_sel(alt_sel), .pull_up(pull_up), .pull_dn(pull_dn), .dig_en(dig_en)
    );

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #1 v = rdata;
    endtask

    // R5/R7: sweep every gated field with four data patterns.
    task automatic sweep(input string req);
        logic [31:0] v;
        logic [N-1:0] pats [4];
        pats[0] = 8'hFF; pats[1] = 8'h00; pats[2] = 8'hA5; pats[3] = 8'h5A;
        for (int f = 1; f < NFIELD; f++) begin
            for (int p = 0; p < 4; p++) begin
                wr(field_ofs(f), {24'hFFFFFF, pats[p]});
                m_cfg[f] = (m_cfg[f] & ~m_cm) | (pats[p] & m_cm);
                rd(field_ofs(f), v);
                chk(req, v, {24'h0, m_cfg[f]});
            end
        end
    endtask

    initial begin
        logic [31:0] v;
        for (int f = 0; f < NFIELD; f++) m_cfg[f] = '0;
        m_cm = ~PROT;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state: R2 locked, R4 commit, R8 fields, R7 unmapped offset.
        rd(OFS_LOCK, v);   chk("R2 reset lock", v, 32'h1);
        rd(OFS_COMMIT, v); chk("R4 reset commit", v, {24'h0, m_cm});
        for (int f = 0; f < NFIELD; f++) begin
            rd(field_ofs(f), v); chk("R8 reset field", v, 32'h0);
        end
        rd(12'h000, v); chk("R7 unmapped read", v, 32'h0);

        // R3: commit writes ignored while locked.
        wr(OFS_COMMIT, 32'hFF);
        rd(OFS_COMMIT, v); chk("R3 locked commit write", v, {24'h0, m_cm});

        // R5: only unprotected pins writable.
        sweep("R5 uncommitted");

        // R1 unlock, R4 commit one protected pin.
        wr(OFS_LOCK, UNLOCK_KEY);
        rd(OFS_LOCK, v); chk("R1 unlocked", v, 32'h0);
        wr(OFS_COMMIT, 32'h04);
        m_cm = ~PROT | 8'h04;
        rd(OFS_COMMIT, v); chk("R4 commit one", v, {24'h0, m_cm});

        // R2 relock with zero; R9 commit persists.
        wr(OFS_LOCK, 32'h0);
        rd(OFS_LOCK, v); chk("R2 relock zero", v, 32'h1);
        rd(OFS_COMMIT, v); chk("R9 commit kept", v, {24'h0, m_cm});
        sweep("R9 committed after relock");
        wr(OFS_COMMIT, 32'h00);
        rd(OFS_COMMIT, v); chk("R3 locked clear ignored", v, {24'h0, m_cm});

        // Both protected pins committed, then none.
        wr(OFS_LOCK, UNLOCK_KEY);
        wr(OFS_COMMIT, 32'hFF);
        m_cm = '1;
        rd(OFS_COMMIT, v); chk("R4 commit all", v, {24'h0, m_cm});
        sweep("R5 all committed");
        wr(OFS_COMMIT, 32'h00);
        m_cm = ~PROT;
        rd(OFS_COMMIT, v); chk("R4 commit cleared", v, {24'h0, m_cm});
        sweep("R5 cleared");

        // R1/R2: exact key unlocks, every one-bit change locks.
        for (int b = 0; b < 32; b++) begin
            wr(OFS_LOCK, UNLOCK_KEY);
            rd(OFS_LOCK, v); chk("R1 key", v, 32'h0);
            wr(OFS_LOCK, UNLOCK_KEY ^ (32'h1 << b));
            rd(OFS_LOCK, v); chk("R2 flipped key", v, 32'h1);
        end

        // R6: direction ungated while locked and uncommitted.
        for (int d = 0; d < 256; d += 37) begin
            wr(OFS_DIR, 32'hFFFFFF00 | d);
            rd(OFS_DIR, v); chk("R6 dir read", v, d);
            chk("R6 dir port", {24'h0, dir_q}, d);
        end

        // R5 port view matches model.
        chk("R5 alt_sel port", {24'h0, alt_sel}, {24'h0, m_cfg[1]});
        chk("R5 dig_en port", {24'h0, dig_en}, {24'h0, m_cfg[4]});
        chk("R4 commit port", {24'h0, commit_mask}, {24'h0, m_cm});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule